// File: doc/BRIEF.md
# Structured-Sparse Signed Dot-Product Engine

This block computes signed dot products between a weight row and a dense activation vector, where the weights were pruned so that each run of four consecutive positions holds no more than two non-zero values. Only the two surviving weights of each run enter the block. Two small position indices come with them and say which two of the four activations they pair with. The engine routes those two activations to its two multipliers and never multiplies the pruned zeros. A run of four elements therefore costs one cycle and two multiplies.

A producer streams one run, called a group, per handshake. The group carries the two kept weights, the four activations, both indices, and flags that mark the first and the last group of a vector. The engine has two stages. The first selects the activations and forms the products. The second adds the products into a 32-bit signed running sum. One cycle after the last group leaves the first stage, the finished sum appears for one cycle together with a flag. The flag reports whether any group of that vector carried indices that were out of order.

Top module: `spdot_engine`

## Requirements
- R1: While reset is asserted, `inReady` and `outValid` are low. `inReady` is high from the first clock edge after reset is released.
- R2: For a group, lane k (k = 0, 1) takes weight `inWeights[8k+7:8k]` and index `inMeta[2k+1:2k]`. That index selects activation `inActs[8j+7:8j]` with j equal to the index. The group contributes the sum of both signed 8-bit lane products.
- R3: A group with `inFirst` high starts a new sum. Nothing from earlier vectors carries into it.
- R4: The groups of one vector add up in arrival order. If the last group (the one with `inLast` high) is accepted at clock edge k, then `outValid` is high and `outResult` holds the sum during the cycle after edge k+1.
- R5: If any group of a vector has lane-0 index greater than or equal to lane-1 index, `outError` is high with that vector's result. The products of that group still use the indices as given. A vector without such a group reports `outError` low.
- R6: `inReady` stays high, so a group can be accepted on every cycle. This includes the cycle in which a result is being emitted. Back-to-back vectors, and vectors of a single group, lose no result.
- R7: Cycles with `inValid` low have no effect on the sum, the error flag or the outputs, whatever the other inputs carry.
- R8: Products and sums are signed two's complement and exact at the operand extremes, for example (-128)·(-128) = 16384 per lane.
- R9: `outValid` is high in exactly one cycle for each accepted last group, and in no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Group present on the input fields |
| inReady | output | 1 | Engine can take a group this cycle |
| inFirst | input | 1 | Group opens a new vector |
| inLast | input | 1 | Group closes the vector |
| inWeights | input | 16 | Two kept signed weights, lane 0 in the low byte |
| inActs | input | 32 | Four signed activations, position 0 in the low byte |
| inMeta | input | 4 | Two 2-bit positions, lane 0 in bits 1:0 |
| outValid | output | 1 | Result present for one cycle |
| outResult | output | 32 | Signed dot-product of the finished vector |
| outError | output | 1 | Vector contained an out-of-order index pair |

## Verification
The bench builds the engine with its default parameters: 8-bit operands, a 32-bit sum, groups of four and two kept lanes. With these values every one of the six legal position pairs and several illegal ones can be driven directly. The values also make the most negative operand easy to reach, so exact signed products at the extremes are checked. Results are predicted per vector while the same groups are driven back to back, split by idle cycles that carry garbage, and packed into single-group vectors. This exposes lost or spurious results around the output cycle.

// File: rtl/spdot_pkg.sv
`timescale 1ns/1ps
package spdot_pkg;
  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic s1Load;    // capture gathered products into stage 1
    logic accLoad;   // stage 2 adds stage-1 products
    logic accClear;  // stage-1 group opens a vector
    logic emit;      // stage-1 group closes a vector
  } spdot_strobe_t;
endpackage

// File: rtl/spdot_ctrl.sv
`timescale 1ns/1ps
module spdot_ctrl
  import spdot_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inFirst,
  input  logic          inLast,
  output logic          inReady,
  output spdot_strobe_t strobes,
  output logic          outValid
);
  logic readyQ;
  logic s1Valid, s1First, s1Last;
  logic outValidQ;
  logic takeGroup;

  assign takeGroup = inValid && readyQ;
  assign inReady   = readyQ;
  assign outValid  = outValidQ;

  always_comb begin
    strobes.s1Load   = takeGroup;
    strobes.accLoad  = s1Valid;
    strobes.accClear = s1Valid && s1First;
    strobes.emit     = s1Valid && s1Last;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      s1Valid   <= 1'b0;
      s1First   <= 1'b0;
      s1Last    <= 1'b0;
      outValidQ <= 1'b0;
    end else begin
      readyQ    <= 1'b1;
      s1Valid   <= takeGroup;
      if (takeGroup) begin
        s1First <= inFirst;
        s1Last  <= inLast;
      end
      outValidQ <= s1Valid && s1Last;
    end
  end

  // a closing group in stage 1 is always followed by a result cycle
  assert_emit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && s1Last) |=> outValid);
  // no result without a closing group one cycle earlier
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(s1Valid && s1Last));
  // once ready, the engine never stalls the producer
  assert_never_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> inReady);
  // a group seen by stage 1 was offered with valid high
  assert_stage_follows_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |-> $past(inValid));
endmodule

// File: rtl/spdot_datapath.sv
`timescale 1ns/1ps
module spdot_datapath
  import spdot_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ACC_W      = 32,
  parameter int GROUP_SIZE = 4,
  parameter int KEEP       = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  spdot_strobe_t              strobes,
  input  logic [KEEP*DATA_W-1:0]     inWeights,
  input  logic [GROUP_SIZE*DATA_W-1:0] inActs,
  input  logic [KEEP*$clog2(GROUP_SIZE)-1:0] inMeta,
  output logic [ACC_W-1:0]           outResult,
  output logic                       outError
);
  localparam int IDX_W  = $clog2(GROUP_SIZE);
  localparam int PROD_W = 2 * DATA_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic        [IDX_W-1:0]  laneIdx [KEEP];
  logic signed [DATA_W-1:0] laneW   [KEEP];
  logic signed [DATA_W-1:0] laneA   [KEEP];
  logic signed [PROD_W-1:0] prodD   [KEEP];
  logic signed [PROD_W-1:0] prodQ   [KEEP];
  logic [KEEP-2:0]          orderBad;
  logic                     s1Err;
  logic signed [ACC_W-1:0]  prodSum, accQ, accBase, accNext;
  logic                     errQ, errNext;

  // gather multiplexers and multipliers, one per kept lane
  for (genvar g = 0; g < KEEP; g++) begin : gLane
    assign laneIdx[g] = inMeta[g*IDX_W +: IDX_W];
    assign laneW[g]   = $signed(inWeights[g*DATA_W +: DATA_W]);
    assign laneA[g]   = $signed(inActs[laneIdx[g]*DATA_W +: DATA_W]);
    assign prodD[g]   = laneW[g] * laneA[g];
  end

  // positions must strictly increase from lane to lane
  for (genvar g = 1; g < KEEP; g++) begin : gOrder
    assign orderBad[g-1] = (laneIdx[g-1] >= laneIdx[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < KEEP; i++) prodQ[i] <= '0;
      s1Err <= 1'b0;
    end else if (strobes.s1Load) begin
      for (int i = 0; i < KEEP; i++) prodQ[i] <= prodD[i];
      s1Err <= |orderBad;
    end
  end

  always_comb begin
    prodSum = '0;
    for (int i = 0; i < KEEP; i++)
      prodSum = prodSum + {{EXT_W{prodQ[i][PROD_W-1]}}, prodQ[i]};
    accBase = strobes.accClear ? '0 : accQ;
    accNext = accBase + prodSum;
    errNext = (strobes.accClear ? 1'b0 : errQ) | s1Err;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ      <= '0;
      errQ      <= 1'b0;
      outResult <= '0;
      outError  <= 1'b0;
    end else if (strobes.accLoad) begin
      accQ <= accNext;
      errQ <= errNext;
      if (strobes.emit) begin
        outResult <= accNext;
        outError  <= errNext;
      end
    end
  end

  // idle cycles leave stage-1 products untouched
  assert_hold_prod_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.s1Load |=> $stable(prodQ[0]));
  // idle cycles leave the running sum untouched
  assert_hold_acc_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accLoad |=> $stable(accQ));
  // an opening group discards the previous sum
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accClear |=> (accQ == $past(prodSum)));
  // a bad pair reaching the closing cycle shows up on the flag
  assert_err_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emit && s1Err) |=> outError);
endmodule

// File: rtl/spdot_engine.sv
`timescale 1ns/1ps
module spdot_engine
  import spdot_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ACC_W      = 32,
  parameter int GROUP_SIZE = 4,
  parameter int KEEP       = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic                         inFirst,
  input  logic                         inLast,
  input  logic [KEEP*DATA_W-1:0]       inWeights,
  input  logic [GROUP_SIZE*DATA_W-1:0] inActs,
  input  logic [KEEP*$clog2(GROUP_SIZE)-1:0] inMeta,
  output logic                         outValid,
  output logic [ACC_W-1:0]             outResult,
  output logic                         outError
);
  spdot_strobe_t strobes;

  spdot_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inFirst  (inFirst),
    .inLast   (inLast),
    .inReady  (inReady),
    .strobes  (strobes),
    .outValid (outValid)
  );

  spdot_datapath #(
    .DATA_W     (DATA_W),
    .ACC_W      (ACC_W),
    .GROUP_SIZE (GROUP_SIZE),
    .KEEP       (KEEP)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inWeights (inWeights),
    .inActs    (inActs),
    .inMeta    (inMeta),
    .outResult (outResult),
    .outError  (outError)
  );
endmodule

// File: tb/sim_spdot_engine.sv
`timescale 1ns/1ps
module sim_spdot_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0;
  logic        inReady;
  logic [15:0] inWeights = '0;
  logic [31:0] inActs = '0;
  logic [3:0]  inMeta = '0;
  logic        outValid, outError;
  logic [31:0] outResult;

  always #4 clk = ~clk;  // 125 MHz

  spdot_engine u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inFirst(inFirst), .inLast(inLast), .inWeights(inWeights),
    .inActs(inActs), .inMeta(inMeta), .outValid(outValid),
    .outResult(outResult), .outError(outError)
  );

  int checks = 0;
  int fails = 0;
  int expSum[$];
  bit expErr[$];
  string expTag[$];
  int modelAcc = 0;
  bit modelErr = 1'b0;
  bit monitorOn = 1'b1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sx8(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  // driver: one group per call, model pushes expected result on last
  task automatic sendGroup(input bit f, input bit l,
                           input logic [7:0] w0, input logic [7:0] w1,
                           input logic [7:0] a0, input logic [7:0] a1,
                           input logic [7:0] a2, input logic [7:0] a3,
                           input logic [1:0] i0, input logic [1:0] i1,
                           input string tag);
    logic [7:0] acts [4];
    acts[0] = a0; acts[1] = a1; acts[2] = a2; acts[3] = a3;
    inValid   = 1'b1;
    inFirst   = f;
    inLast    = l;
    inWeights = {w1, w0};
    inActs    = {a3, a2, a1, a0};
    inMeta    = {i1, i0};
    if (f) begin modelAcc = 0; modelErr = 1'b0; end
    modelAcc = modelAcc + sx8(w0) * sx8(acts[i0]) + sx8(w1) * sx8(acts[i1]);
    if (i0 >= i1) modelErr = 1'b1;
    if (l) begin
      expSum.push_back(modelAcc);
      expErr.push_back(modelErr);
      expTag.push_back(tag);
    end
    @(negedge clk);
  endtask

  // idle cycles with garbage on every field (R7)
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      inValid   = 1'b0;
      inFirst   = 1'($urandom);
      inLast    = 1'($urandom);
      inWeights = 16'($urandom);
      inActs    = $urandom;
      inMeta    = 4'($urandom);
      @(negedge clk);
    end
  endtask

  // monitor: compare every emitted result with the scoreboard
  always @(negedge clk) begin
    if (rstN && monitorOn && outValid) begin
      if (expSum.size() == 0) begin
        check(1'b0, "R9 unexpected result", outResult, 0);
      end else begin
        automatic int es = expSum.pop_front();
        automatic bit ee = expErr.pop_front();
        automatic string et = expTag.pop_front();
        check($signed(outResult) == es, {et, " sum"}, $signed(outResult), es);
        check(outError == ee, {et, " R5 error flag"}, outError, ee);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(inReady == 1'b0, "R1 inReady in reset", inReady, 0);
    check(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 inReady after reset", inReady, 1);
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);

    // R4 latency with a single group: 3*30 + (-2)*10 = 70
    sendGroup(1, 1, 8'd3, 8'hFE, 8'd10, 8'd20, 8'd30, 8'd40, 2'd2, 2'd0, "R4 single");
    // that one is illegal (2>=0): use a legal pair instead below; expected still modelled
    inValid = 1'b0;
    check(outValid == 1'b0, "R4 not yet after one edge", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b1, "R4 result after two edges", outValid, 1);
    @(negedge clk);
    check(outValid == 1'b0, "R9 single-cycle pulse", outValid, 0);

    // R2: all six legal position pairs in one vector, R4 accumulation
    sendGroup(1, 0, 8'd2, 8'd3, 8'd1, 8'd5, 8'd9, 8'd13, 2'd0, 2'd1, "R2 pairs");
    sendGroup(0, 0, 8'd4, 8'hFB, 8'd7, 8'd11, 8'hF0, 8'd2, 2'd0, 2'd2, "R2 pairs");
    sendGroup(0, 0, 8'd6, 8'd1, 8'd3, 8'd0, 8'd8, 8'h81, 2'd0, 2'd3, "R2 pairs");
    sendGroup(0, 0, 8'hF9, 8'd9, 8'd50, 8'd4, 8'd6, 8'd20, 2'd1, 2'd2, "R2 pairs");
    sendGroup(0, 0, 8'd10, 8'd0, 8'd99, 8'h9C, 8'd1, 8'd77, 2'd1, 2'd3, "R2 pairs");
    sendGroup(0, 1, 8'd1, 8'd2, 8'd5, 8'd5, 8'd17, 8'd19, 2'd2, 2'd3, "R2 R4 pairs");
    idle(3);

    // R3: new vector ignores previous sum
    sendGroup(1, 1, 8'd1, 8'd1, 8'd4, 8'd5, 8'd6, 8'd7, 2'd0, 2'd1, "R3 restart");
    idle(2);

    // R7: garbage bubbles between groups of one vector
    sendGroup(1, 0, 8'd12, 8'd3, 8'd1, 8'd2, 8'd3, 8'd4, 2'd1, 2'd3, "R7 bubbles");
    idle(4);
    sendGroup(0, 0, 8'hF0, 8'd7, 8'd9, 8'd8, 8'd7, 8'd6, 2'd0, 2'd2, "R7 bubbles");
    idle(1);
    sendGroup(0, 1, 8'd5, 8'd5, 8'd2, 8'd2, 8'd2, 8'd2, 2'd2, 2'd3, "R7 bubbles");
    idle(3);

    // R5: out-of-order pair 2,1 -> 5*3 + 7*2 = 29, flag set; next vector clean
    sendGroup(1, 0, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 2'd0, 2'd3, "R5 bad");
    sendGroup(0, 1, 8'd5, 8'd7, 8'd1, 8'd2, 8'd3, 8'd4, 2'd2, 2'd1, "R5 bad");
    sendGroup(1, 1, 8'd5, 8'd7, 8'd1, 8'd2, 8'd3, 8'd4, 2'd1, 2'd2, "R5 clean");
    sendGroup(1, 1, 8'd2, 8'd2, 8'd9, 8'd9, 8'd9, 8'd9, 2'd1, 2'd1, "R5 equal");
    idle(3);

    // R8: operand extremes
    sendGroup(1, 0, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 2'd0, 2'd3, "R8 extremes");
    sendGroup(0, 0, 8'h80, 8'h7F, 8'h7F, 8'h80, 8'h7F, 8'h80, 2'd0, 2'd1, "R8 extremes");
    sendGroup(0, 1, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 2'd1, 2'd2, "R8 extremes");
    idle(3);

    // R6: back-to-back single-group vectors, result cycles overlap inputs
    for (int v = 0; v < 6; v++)
      sendGroup(1, 1, 8'(v + 1), 8'hFF, 8'(v), 8'd3, 8'(2 * v), 8'd9, 2'd0, 2'(1 + v % 3), "R6 back-to-back");
    idle(3);

    // random vectors with occasional bubbles and bad pairs
    for (int v = 0; v < 60; v++) begin
      automatic int len = 1 + int'($urandom % 6);
      for (int g = 0; g < len; g++) begin
        automatic logic [1:0] p0 = 2'($urandom % 3);
        automatic logic [1:0] p1 = 2'(p0 + 1 + ($urandom % (3 - p0)));
        if ($urandom % 10 == 0) p1 = p0;
        sendGroup(g == 0, g == len - 1, 8'($urandom), 8'($urandom),
                  8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                  p0, p1, "R2 R4 R6 random");
        if ($urandom % 4 == 0) idle(1 + int'($urandom % 2));
      end
    end
    idle(5);

    // R6: no result lost or left over
    check(expSum.size() == 0, "R6 scoreboard drained", expSum.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule